// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog for a small 8-bit controller. It is off after reset. Software starts it by writing a two-byte key, 0x1E followed by 0xE1, to one write-only register address. The same key, written while the watchdog runs, restarts the count. Once started, the watchdog stays on until a hardware reset or until it times out itself.

While running, a 14-bit counter advances on machine-cycle ticks. A prescaler with a 3-bit select stretches each count step to 2^n ticks. When the count reaches its last value, the block drives an active-high reset pulse of fixed length. The same event returns the block to its off state.

The host bus gives address, data and a write strobe. The tick input marks each machine cycle.

Top module: `key_watchdog`

## Requirements
- R1: After rst_ni is released, rst_pulse_o is low, the watchdog is off, and no pulse appears however long tick_i runs. An assertion of rst_ni in mid-run turns the watchdog off again.
- R2: While the watchdog is on, the count advances only on clock cycles in which tick_i is high. Cycles with tick_i low lengthen the timeout by exactly their number.
- R3: The key is two strobed writes to address 0xA6: first data 0x1E, then data 0xE1. A write of any other value to 0xA6 after 0x1E cancels the key. Writes to other addresses leave the key progress unchanged.
- R4: With presc_sel_i = 0 and tick_i held high, rst_pulse_o rises 16383 clock cycles after the edge that captures the 0xE1 write.
- R5: A complete key written while the watchdog is on restarts the count. The pulse then rises 16383 ticks after the edge that captures that 0xE1 write.
- R6: The reset pulse is active high and lasts exactly 96 clock cycles.
- R7: After a timeout pulse the watchdog is off. No further pulse comes until a new key is written.
- R8: No register write turns the watchdog off. Writing other values to 0xA6 while it runs does not prevent the timeout.
- R9: With presc_sel_i = n, the count advances once every 2^n ticks, so the timeout is 16383 * 2^n ticks.
- R10: Key writes made while the reset pulse is high are ignored and do not turn the watchdog on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Machine-cycle enable |
| presc_sel_i | input | 3 | Prescaler select n; step every 2^n ticks |
| rst_pulse_o | output | 1 | Active-high reset pulse on timeout |

## Verification
The stimulus runs through several key patterns, and each one separates a correct key decoder from a wrong one:
- A broken key (0x1E, 0x55, 0xE1) must not start the watchdog.
- A key with a write to another address between its two bytes must still start it.
- Stray values written to the key address after start must not stop it.
- A key written during the pulse must have no effect.

Timing is checked against an exact cycle number in four cases: a clean start, a restart in mid-count, a gap in tick_i, and a nonzero prescaler select. These separate off-by-one errors in the counter, a prescaler that ignores its select, and service writes that do not clear the count. Quiet windows longer than one full timeout show that the block stays off after reset, after a mid-run reset, and after its own pulse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              key_ok_o
);
  seq_state_e st_q, st_d;
  logic       hit;

  assign hit = wr_en_i && (wr_addr_i == KEY_ADDR);

  always_comb begin
    st_d     = st_q;
    key_ok_o = 1'b0;
    if (clr_i) begin
      st_d = SEQ_IDLE;
    end else if (hit) begin
      if (wr_data_i == KEY_FIRST) begin
        st_d = SEQ_ARMED;
      end else begin
        if (st_q == SEQ_ARMED && wr_data_i == KEY_SECOND) key_ok_o = 1'b1;
        st_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  AST_FOREIGN_ADDR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(wr_en_i && wr_addr_i == KEY_ADDR)) |=> $stable(st_q)); // R3
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int SEL_W = 3,
  localparam int PRE_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [PRE_W-1:0] div_q, lim;

  // limit = 2^sel - 1, built as a thermometer code
  always_comb begin
    for (int i = 0; i < PRE_W; i++) lim[i] = (i < int'(sel_i));
  end

  assign step_o = run_i && tick_i && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i)           div_q <= '0;
    else if (run_i && tick_i) div_q <= step_o ? '0 : div_q + 1'b1;
  end

  AST_DIV_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(div_q)); // R2
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] TRIP = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = step_i && (cnt_q == TRIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || ovf_o) cnt_q <= '0;
    else if (step_i)         cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R2
  AST_CNT_NEVER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != LAST); // R4
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int PULSE_LEN = 96,
  localparam int PULSE_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  logic [PULSE_W-1:0] len_q;

  assign pulse_o = (len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  len_q <= '0;
    else if (fire_i && !pulse_o)  len_q <= PULSE_W'(PULSE_LEN);
    else if (pulse_o)             len_q <= len_q - 1'b1;
  end

  AST_PULSE_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_o); // R6
  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !fire_i); // R7
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  KEY_ADDR   = 8'hA6,
  parameter logic [7:0]  KEY_FIRST  = 8'h1E,
  parameter logic [7:0]  KEY_SECOND = 8'hE1,
  parameter int          CNT_W      = 14,
  parameter int          SEL_W      = 3,
  parameter int          PULSE_LEN  = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic [SEL_W-1:0]  presc_sel_i,
  output logic              rst_pulse_o
);
  logic en_q, key_ok, step, ovf, wd_clr, cnt_clr;

  assign wd_clr  = ovf || rst_pulse_o;
  assign cnt_clr = wd_clr || key_ok;

  kwd_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(ADDR_W'(KEY_ADDR)), .KEY_FIRST(DATA_W'(KEY_FIRST)),
    .KEY_SECOND(DATA_W'(KEY_SECOND))
  ) u_key (
    .clk_i, .rst_ni, .clr_i(wd_clr),
    .wr_en_i, .wr_addr_i, .wr_data_i, .key_ok_o(key_ok)
  );

  kwd_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .run_i(en_q),
    .tick_i, .sel_i(presc_sel_i), .step_o(step)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .step_i(step), .ovf_o(ovf)
  );

  kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .fire_i(ovf), .pulse_o(rst_pulse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (wd_clr) en_q <= 1'b0;
    else if (key_ok) en_q <= 1'b1;
  end

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !ovf) |=> en_q); // R8
  AST_OVF_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> !en_q); // R7
  AST_PULSE_BLOCKS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !en_q); // R10
  AST_OFF_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !ovf); // R1
endmodule

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb;
  localparam int TMO = 16383;
  localparam int PLEN = 96;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tick_i = 1'b0;
  logic [2:0] presc_sel_i = '0;
  logic       rst_pulse_o;

  key_watchdog u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tick_i, .presc_sel_i, .rst_pulse_o
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int    n_tests = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    pulses = 0, width = 0;
  bit    prev = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: compare each pulse against the scoreboard queue
  always @(negedge clk_i) begin
    int    e;
    string t;
    if (rst_pulse_o && !prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R7 unexpected pulse", cyc, -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, cyc, e);
      end
      width = 1;
    end else if (rst_pulse_o) begin
      width++;
    end else if (prev) begin
      check(width == PLEN, "R6 pulse width", width, PLEN);
      pulses++;
    end
    prev = rst_pulse_o;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic unlock(output int c);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    c = cyc;
  endtask

  task automatic push(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic wait_done(input int target);
    while (pulses < target) @(negedge clk_i);
  endtask

  task automatic quiet(input int n, input string tag);
    int p0 = pulses;
    repeat (n) @(negedge clk_i);
    check(pulses == p0 && !rst_pulse_o, tag, pulses - p0, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int c, c2, np;
    np = 0;
    tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(rst_pulse_o == 1'b0, "R1 reset state", rst_pulse_o, 0);
    rst_ni = 1'b1;

    // R1: never started
    quiet(16400, "R1 idle without key");

    // R3: broken key
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    quiet(16400, "R3 broken key");

    // R3/R4: foreign write inside key, R8: stray writes after start
    wr(8'hA6, 8'h1E); wr(8'h80, 8'h00); wr(8'hA6, 8'hE1);
    c = cyc;
    push(c + TMO, "R4 timeout");
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'h1E);
    while (!rst_pulse_o) @(negedge clk_i);
    unlock(c2); // R10 key during pulse
    np++; wait_done(np);
    quiet(16400, "R7/R10 off after pulse");

    // R5: service restarts count
    unlock(c);
    repeat (2000) @(negedge clk_i);
    unlock(c2);
    push(c2 + TMO, "R5 service");
    np++; wait_done(np);

    // R2: tick gap
    unlock(c);
    repeat (100) @(negedge clk_i);
    tick_i = 1'b0;
    repeat (2000) @(negedge clk_i);
    tick_i = 1'b1;
    push(c + TMO + 2000, "R2 tick gating");
    np++; wait_done(np);

    // R9: prescaler n=1
    presc_sel_i = 3'd1;
    unlock(c);
    push(c + TMO * 2, "R9 prescaler");
    np++; wait_done(np);
    presc_sel_i = 3'd0;

    // R1: reset in mid-run
    unlock(c);
    repeat (100) @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    quiet(16400, "R1 mid-run reset");

    check(exp_q.size() == 0, "R4 missing pulses", exp_q.size(), 0);
    finish_run();
  end
endmodule